// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Manager

This block keeps an SDR SDRAM refreshed. A free-running interval timer earns one refresh credit every `REF_INTERVAL` clock cycles. This interval is the required average gap (64 ms spread over 4096 rows, about 15.6 µs) expressed in clocks. Credits collect in a small deficit counter, so the command sequencer can postpone refreshes while it is busy with host traffic. The block presents a refresh request while credits are owed. When the postponed count reaches `MAX_DEFICIT`, the request is marked urgent and the sequencer must put it ahead of host commands. Each granted AUTO REFRESH is followed by a command hold that lasts the row cycle time. The device generates the bank and row itself, so the sequencer drives any address.

The block also manages self-refresh. The host asks for it with a level request. The block enters only when the sequencer reports every bank precharged, and it does so by dropping CKE. CKE stays low for at least the minimum active time and for as long as the request remains. After CKE rises, the block holds off all commands for the wake-up window. That window is two clocks or the row cycle time, whichever is longer. The row the device refreshed last is unknown at that point, so the block then demands a back-to-back burst of `FLUSH_ROWS` urgent refreshes before it returns to normal operation.

Top module: `sdram_refresh_mgr`

## Requirements
- R1: While reset is high and on the first cycle after it, CKE is high and the request, urgent, hold and status outputs are all low.
- R2: In normal operation, one refresh credit is earned every `REF_INTERVAL` cycles. The first credit after reset makes the request visible exactly `REF_INTERVAL` cycles after reset is released.
- R3: A grant is accepted only in a cycle where the request is high. After an accepted grant, the command hold stays high and the request stays low for exactly `T_RC` cycles.
- R4: The deficit saturates at `MAX_DEFICIT`. Urgent is high only together with the request, and it rises when the deficit reaches the limit. Credits earned while the deficit is saturated are lost.
- R5: A grant that arrives while the request is low has no effect: no hold starts and no credit is spent.
- R6: Self-refresh is entered only when the self-refresh request and the all-banks-idle input are both high and no hold is running. CKE is low on the next cycle, and credits still owed are dropped.
- R7: CKE stays low for at least `T_RAS` cycles, and for as long as the self-refresh request stays high. While CKE is low, the hold and the status output are high and no refresh is requested.
- R8: After CKE rises, the hold stays high and no refresh is requested for max(2, `T_RC`) cycles.
- R9: After the wake window, exactly `FLUSH_ROWS` refreshes are requested, each one urgent, and the hold stays high throughout. The status output falls once the last one has been granted.
- R10: After a flush, the interval timer restarts from zero, so the next periodic request comes `REF_INTERVAL` cycles after the status output falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sr_req_i | input | 1 | Level request to enter and stay in self-refresh |
| banks_idle_i | input | 1 | Sequencer reports all banks precharged |
| ref_gnt_i | input | 1 | Sequencer issues AUTO REFRESH this cycle |
| ref_req_o | output | 1 | Refresh requested |
| ref_urgent_o | output | 1 | Refresh must preempt host traffic |
| cke_o | output | 1 | Clock enable to the SDRAM |
| cmd_hold_o | output | 1 | No non-refresh command may be issued |
| sr_busy_o | output | 1 | A self-refresh cycle (entry, wake or flush) is in progress |

## Verification
The bench builds the block with a 20-cycle interval, a 3-cycle row cycle time, a 4-cycle minimum low time, a deficit limit of 3 and a 5-row flush. With these values, saturation, lost credits and complete flush bursts all fall within a few hundred cycles. The self-refresh sequence runs twice: once with a one-cycle request, so the minimum low time sets the length, and once with a nine-cycle request, so the request sets it. The bench counts every low, wake and flush cycle and compares each count with the value worked out from the parameters.

// File: rtl/sdram_rfm_pkg.sv
package sdram_rfm_pkg;
  typedef enum logic [1:0] {
    RFM_RUN   = 2'd0,
    RFM_SELF  = 2'd1,
    RFM_WAKE  = 2'd2,
    RFM_FLUSH = 2'd3
  } rfm_state_t;
endpackage

// File: rtl/rfm_interval.sv
// Earns one refresh credit per REF_INTERVAL enabled cycles; restarts when disabled.
module rfm_interval #(
  parameter int REF_INTERVAL = 1560
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(REF_INTERVAL - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rfm_debt.sv
// Outstanding refresh count: saturating credit in normal use, preloaded for a flush.
module rfm_debt #(
  parameter int MAX_DEFICIT = 8,
  parameter int FLUSH_ROWS  = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic load_i,
  input  logic tick_i,
  input  logic take_i,
  output logic owed_o,
  output logic at_limit_o
);
  localparam int CAP = (FLUSH_ROWS > MAX_DEFICIT) ? FLUSH_ROWS : MAX_DEFICIT;
  localparam int PW  = $clog2(CAP + 1);
  localparam logic [PW-1:0] LIMIT = PW'(MAX_DEFICIT);
  localparam logic [PW-1:0] ROWS  = PW'(FLUSH_ROWS);

  logic [PW-1:0] owed_q;

  assign owed_o     = (owed_q != '0);
  assign at_limit_o = (owed_q >= LIMIT);

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      owed_q <= '0;
    end else if (load_i) begin
      owed_q <= ROWS;
    end else begin
      unique case ({tick_i, take_i})
        2'b10:   if (owed_q < LIMIT) owed_q <= owed_q + 1'b1;
        2'b01:   if (owed_q != '0)   owed_q <= owed_q - 1'b1;
        default: owed_q <= owed_q;
      endcase
    end
  end
endmodule

// File: rtl/rfm_hold.sv
// Blocks commands for T_RC cycles after each issued refresh.
module rfm_hold #(
  parameter int T_RC = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o
);
  localparam int HW = $clog2(T_RC + 1);

  logic [HW-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= HW'(T_RC);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rfm_sr_ctrl.sv
// Self-refresh sequence: entry, minimum low time, wake window, flush.
module rfm_sr_ctrl
  import sdram_rfm_pkg::*;
#(
  parameter int T_RAS = 5,
  parameter int T_RC  = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sr_req_i,
  input  logic       banks_idle_i,
  input  logic       hold_busy_i,
  input  logic       take_i,
  input  logic       owed_i,
  output rfm_state_t state_o,
  output logic       cke_o,
  output logic       enter_o,
  output logic       wake_done_o
);
  localparam int WAKE_CYC = (T_RC > 2) ? T_RC : 2;
  localparam int TMAX     = (T_RAS > WAKE_CYC) ? T_RAS : WAKE_CYC;
  localparam int TW       = $clog2(TMAX + 1);

  rfm_state_t    state_q;
  logic [TW-1:0] tmr_q;
  logic          cke_q;

  assign state_o     = state_q;
  assign cke_o       = cke_q;
  assign enter_o     = (state_q == RFM_RUN) && sr_req_i && banks_idle_i &&
                       !hold_busy_i && !take_i;
  assign wake_done_o = (state_q == RFM_WAKE) && (tmr_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RFM_RUN;
      tmr_q   <= '0;
      cke_q   <= 1'b1;
    end else begin
      unique case (state_q)
        RFM_RUN: begin
          if (enter_o) begin
            state_q <= RFM_SELF;
            cke_q   <= 1'b0;
            tmr_q   <= TW'(T_RAS - 1);
          end
        end
        RFM_SELF: begin
          if (tmr_q != '0) begin
            tmr_q <= tmr_q - 1'b1;
          end else if (!sr_req_i) begin
            state_q <= RFM_WAKE;
            cke_q   <= 1'b1;
            tmr_q   <= TW'(WAKE_CYC - 1);
          end
        end
        RFM_WAKE: begin
          if (tmr_q != '0) begin
            tmr_q <= tmr_q - 1'b1;
          end else begin
            state_q <= RFM_FLUSH;
          end
        end
        RFM_FLUSH: begin
          if (!owed_i) state_q <= RFM_RUN;
        end
        default: state_q <= RFM_RUN;
      endcase
    end
  end
endmodule

// File: rtl/sdram_refresh_mgr.sv
module sdram_refresh_mgr
  import sdram_rfm_pkg::*;
#(
  parameter int REF_INTERVAL = 1560,
  parameter int T_RC         = 7,
  parameter int T_RAS        = 5,
  parameter int MAX_DEFICIT  = 8,
  parameter int FLUSH_ROWS   = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic sr_req_i,
  input  logic banks_idle_i,
  input  logic ref_gnt_i,
  output logic ref_req_o,
  output logic ref_urgent_o,
  output logic cke_o,
  output logic cmd_hold_o,
  output logic sr_busy_o
);
  rfm_state_t state;
  logic tick, owed, at_limit, hold_busy, take, enter, wake_done;
  logic may_refresh;

  assign may_refresh  = (state == RFM_RUN) || (state == RFM_FLUSH);
  assign ref_req_o    = owed && !hold_busy && may_refresh;
  assign take         = ref_gnt_i && ref_req_o;
  assign ref_urgent_o = ref_req_o && (at_limit || (state == RFM_FLUSH));
  assign cmd_hold_o   = hold_busy || (state != RFM_RUN);
  assign sr_busy_o    = (state != RFM_RUN);

  rfm_interval #(.REF_INTERVAL(REF_INTERVAL)) u_interval (
    .clk    (clk),
    .rst    (rst),
    .en_i   (state == RFM_RUN),
    .tick_o (tick)
  );

  rfm_debt #(.MAX_DEFICIT(MAX_DEFICIT), .FLUSH_ROWS(FLUSH_ROWS)) u_debt (
    .clk        (clk),
    .rst        (rst),
    .clear_i    (enter),
    .load_i     (wake_done),
    .tick_i     (tick),
    .take_i     (take),
    .owed_o     (owed),
    .at_limit_o (at_limit)
  );

  rfm_hold #(.T_RC(T_RC)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .start_i (take),
    .busy_o  (hold_busy)
  );

  rfm_sr_ctrl #(.T_RAS(T_RAS), .T_RC(T_RC)) u_sr (
    .clk          (clk),
    .rst          (rst),
    .sr_req_i     (sr_req_i),
    .banks_idle_i (banks_idle_i),
    .hold_busy_i  (hold_busy),
    .take_i       (take),
    .owed_i       (owed),
    .state_o      (state),
    .cke_o        (cke_o),
    .enter_o      (enter),
    .wake_done_o  (wake_done)
  );
endmodule

// File: rtl/rfm_checker.sv
module rfm_checker #(
  parameter int T_RAS = 5
) (
  input logic clk,
  input logic rst,
  input logic sr_req_i,
  input logic banks_idle_i,
  input logic ref_gnt_i,
  input logic ref_req_o,
  input logic ref_urgent_o,
  input logic cke_o,
  input logic cmd_hold_o,
  input logic sr_busy_o
);
  localparam int LW = $clog2(T_RAS + 1);
  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || cke_o) low_cnt <= '0;
    else if (low_cnt != LW'(T_RAS)) low_cnt <= low_cnt + 1'b1;
  end

  assert_grant_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (ref_gnt_i && ref_req_o) |=> (cmd_hold_o && !ref_req_o));

  assert_urgent_needs_req_R4: assert property (@(posedge clk) disable iff (rst)
    ref_urgent_o |-> ref_req_o);

  assert_stray_grant_R5: assert property (@(posedge clk) disable iff (rst)
    (ref_gnt_i && !ref_req_o && !cmd_hold_o && !sr_req_i) |=> !cmd_hold_o);

  assert_entry_idle_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(cke_o) |-> ($past(banks_idle_i) && $past(sr_req_i)));

  assert_sr_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !cke_o |-> (cmd_hold_o && !ref_req_o && sr_busy_o));

  assert_min_low_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(cke_o) |-> (low_cnt == LW'(T_RAS)));

  assert_wake_nop_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(cke_o) |-> (cmd_hold_o && !ref_req_o));
endmodule

bind sdram_refresh_mgr rfm_checker #(.T_RAS(T_RAS)) u_rfm_chk (
  .clk          (clk),
  .rst          (rst),
  .sr_req_i     (sr_req_i),
  .banks_idle_i (banks_idle_i),
  .ref_gnt_i    (ref_gnt_i),
  .ref_req_o    (ref_req_o),
  .ref_urgent_o (ref_urgent_o),
  .cke_o        (cke_o),
  .cmd_hold_o   (cmd_hold_o),
  .sr_busy_o    (sr_busy_o)
);

// File: tb/sim_sdram_refresh_mgr.sv
module sim_sdram_refresh_mgr;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 20;
  localparam int TRC  = 3;
  localparam int TRAS = 4;
  localparam int MAXD = 3;
  localparam int ROWS = 5;
  localparam int WAKE = (TRC > 2) ? TRC : 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sr_req = 1'b0, banks_idle = 1'b0, gnt = 1'b0;
  logic req, urgent, cke, hold, busy;
  int checks = 0;
  int errors = 0;

  sdram_refresh_mgr #(
    .REF_INTERVAL(N), .T_RC(TRC), .T_RAS(TRAS),
    .MAX_DEFICIT(MAXD), .FLUSH_ROWS(ROWS)
  ) u0 (
    .clk(clk), .rst(rst), .sr_req_i(sr_req), .banks_idle_i(banks_idle),
    .ref_gnt_i(gnt), .ref_req_o(req), .ref_urgent_o(urgent), .cke_o(cke),
    .cmd_hold_o(hold), .sr_busy_o(busy)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_sr(input int stay);
    int low, expect_low, n, guard, c;
    banks_idle = 1'b1;
    sr_req = 1'b1;
    step();
    chk(cke == 1'b0, "R6 entry cke", cke, 0);
    chk(busy == 1'b1, "R6 entry status", busy, 1);
    low = 0;
    while (cke == 1'b0 && low < 1000) begin
      chk(hold && !req && busy, "R7 quiet in self-refresh", {hold, req, busy}, 3'b101);
      low++;
      if (low == stay) sr_req = 1'b0;
      step();
    end
    expect_low = (stay > TRAS) ? stay : TRAS;
    chk(low == expect_low, "R7 cke low cycles", low, expect_low);
    for (int k = 0; k < WAKE; k++) begin
      chk(cke && hold && !req, "R8 wake window", {cke, hold, req}, 3'b110);
      step();
    end
    chk(req && urgent, "R9 flush urgent request", {req, urgent}, 2'b11);
    n = 0;
    guard = 0;
    while (busy && guard < 500) begin
      chk(hold == 1'b1, "R9 hold during flush", hold, 1);
      if (req) begin
        chk(urgent == 1'b1, "R9 flush urgency", urgent, 1);
        gnt = 1'b1;
        step();
        gnt = 1'b0;
        n++;
      end else begin
        step();
      end
      guard++;
    end
    chk(n == ROWS, "R9 flush refresh count", n, ROWS);
    c = 0;
    while (!req && c < 5 * N) begin
      step();
      c++;
    end
    chk(c == N, "R10 first request after flush", c, N);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cke && !req && !urgent && !hold && !busy, "R1 reset outputs",
        {cke, req, urgent, hold, busy}, 5'b10000);
    rst = 1'b0;
    chk(cke && !req && !hold && !busy, "R1 after release", {cke, req, hold, busy}, 4'b1000);

    repeat (N - 1) step();
    chk(req == 1'b0, "R2 no request before interval", req, 0);
    step();
    chk(req == 1'b1, "R2 request at interval", req, 1);
    chk(urgent == 1'b0, "R4 one credit not urgent", urgent, 0);
    repeat (N) step();
    chk(urgent == 1'b0, "R4 two credits not urgent", urgent, 0);
    repeat (N) step();
    chk(urgent == 1'b1, "R4 urgent at limit", urgent, 1);
    repeat (2 * N) step();

    for (int g = 0; g < MAXD; g++) begin
      chk(req == 1'b1, "R4 saturated credit present", req, 1);
      gnt = 1'b1;
      step();
      gnt = 1'b0;
      for (int k = 0; k < TRC; k++) begin
        chk(hold && !req, "R3 hold after grant", {hold, req}, 2'b10);
        step();
      end
      chk(hold == 1'b0, "R3 hold ends after T_RC", hold, 0);
    end
    chk(req == 1'b0, "R4 lost credits at saturation", req, 0);

    gnt = 1'b1;
    step();
    gnt = 1'b0;
    chk(hold == 1'b0, "R5 stray grant no hold", hold, 0);
    chk(req == 1'b0, "R5 stray grant no request", req, 0);
    repeat (N - 13 - 1) step();
    chk(req == 1'b0, "R2 periodic before tick", req, 0);
    step();
    chk(req == 1'b1, "R2 periodic tick", req, 1);

    banks_idle = 1'b0;
    sr_req = 1'b1;
    repeat (4) step();
    chk(cke && !busy, "R6 entry blocked without idle banks", {cke, busy}, 2'b10);

    run_sr(1);
    run_sr(9);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule